// File: doc/BRIEF.md
# Tiny Register-Immediate Processor Core

This block is a small single-cycle processor. Every clock cycle it presents a program-counter value, receives one 14-bit instruction word from a program memory, decodes it, and executes it. It has eight general registers and a single compare flag. The instruction set has eight opcodes:

- add an immediate to a register
- load an immediate into a register
- compare a register against an immediate
- jump unconditionally
- jump only when the flag is set
- store a register to a memory-mapped address
- load a register from a memory-mapped address
- an idle code that does nothing

The core drives a simple data bus with an 8-bit address, separate read and write strobes, write data, and read data returned in the same cycle. The system places its peripherals and scratch memory on this bus. The program memory must answer combinationally, so the instruction for the current program-counter value is present in the same cycle. No instruction takes more than one cycle.

Top module: `tiny_rimm_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, clears all eight registers to 0 and clears the compare flag to 0.
- R2: After any instruction that is not a taken jump, the program counter advances by 1 on the next rising edge. It wraps from 2047 to 0.
- R3: Opcode 000 (bits [13:11]) writes reg+imm, modulo 2^DATA_W, to the register selected by bits [10:8]. The immediate is bits [7:0].
- R4: Opcode 010 writes the zero-extended immediate bits [7:0] to the selected register.
- R5: Opcode 001 sets the flag to 1 when the selected register differs from the immediate, and to 0 when they are equal. It leaves every register unchanged. No other opcode changes the flag.
- R6: Opcode 011 loads the program counter with the target in bits [10:0].
- R7: Opcode 100 loads the program counter with the target in bits [10:0] when the flag is 1. When the flag is 0 it advances the program counter by 1.
- R8: Opcode 110 drives the write strobe high, the bus address with bits [7:0] and the write data with the selected register, all in the same cycle as the instruction. The read strobe stays low and no register changes.
- R9: Opcode 111 drives the read strobe high and the bus address with bits [7:0]. The read data present in that cycle is written to the selected register at the next rising edge.
- R10: Opcode 101 has no effect. Both strobes stay low, and no register and not the flag change.
- R11: The read and write strobes are never high together. Both are low for every opcode other than 110 and 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 11 | Program counter, registered, addresses the program memory |
| instr_i | input | 14 | Instruction word for the current program counter |
| dbus_addr_o | output | 8 | Data bus address (immediate field) |
| dbus_rd_o | output | 1 | Data bus read strobe |
| dbus_wr_o | output | 1 | Data bus write strobe |
| dbus_wdata_o | output | DATA_W | Data bus write data (selected register) |
| dbus_rdata_i | input | DATA_W | Data bus read data, sampled in the strobe cycle |

## Verification
Bus strobes, the address and the write data are combinational from the current instruction, so they are due in the same cycle the instruction is presented. The program counter, the registers and the flag change only at the next rising edge. Register contents are never visible directly: a later store puts them on the write data, and the flag shows through the path a conditional jump takes. The bench runs a reference model in lockstep. At each falling edge it first compares the outputs for the instruction now present against the model, and only then advances the model to the state due after the coming rising edge.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int INSTR_W = 14;
  localparam int OPC_W   = 3;
  localparam int IMM_W   = 8;
  localparam int TGT_W   = 11;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD   = 3'b000,
    OP_CMP   = 3'b001,
    OP_MOVI  = 3'b010,
    OP_JMP   = 3'b011,
    OP_JMPNE = 3'b100,
    OP_IDLE  = 3'b101,
    OP_STORE = 3'b110,
    OP_LOAD  = 3'b111
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_PASS = 2'b01,
    ALU_CMP  = 2'b10
  } alu_op_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    jump;
    logic    jump_ne;
    logic    reg_we;
    logic    flag_we;
    logic    sel_mem;
    logic    mem_rd;
    logic    mem_wr;
  } ctrl_t;
endpackage

// File: rtl/trc_decoder.sv
module trc_decoder
  import trc_pkg::*;
(
  input  opcode_e op,
  output ctrl_t   ctrl
);
  always_comb begin
    ctrl = '{alu_op: ALU_ADD, default: 1'b0};
    case (op)
      OP_ADD:   begin ctrl.alu_op = ALU_ADD;  ctrl.reg_we = 1'b1; end
      OP_CMP:   begin ctrl.alu_op = ALU_CMP;  ctrl.flag_we = 1'b1; end
      OP_MOVI:  begin ctrl.alu_op = ALU_PASS; ctrl.reg_we = 1'b1; end
      OP_JMP:   ctrl.jump = 1'b1;
      OP_JMPNE: ctrl.jump_ne = 1'b1;
      OP_STORE: ctrl.mem_wr = 1'b1;
      OP_LOAD:  begin
        ctrl.alu_op  = ALU_PASS;
        ctrl.reg_we  = 1'b1;
        ctrl.sel_mem = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      default:  ctrl = '{alu_op: ALU_ADD, default: 1'b0};
    endcase
  end
endmodule

// File: rtl/trc_regfile.sv
module trc_regfile #(
  parameter int DATA_W    = 8,
  parameter int REG_COUNT = 8,
  localparam int SEL_W    = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] regs_q [REG_COUNT];

  genvar g;
  generate
    for (g = 0; g < REG_COUNT; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          regs_q[g] <= '0;
        end else if (we && (sel == SEL_W'(g))) begin
          regs_q[g] <= wdata;
        end
      end
    end
  endgenerate

  assign rdata = regs_q[sel];
endmodule

// File: rtl/trc_alu.sv
module trc_alu
  import trc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] result,
  output logic              differ
);
  always_comb begin
    case (op)
      ALU_ADD:  result = a + b;
      ALU_PASS: result = b;
      default:  result = a;
    endcase
  end

  assign differ = (a != b);
endmodule

// File: rtl/tiny_rimm_core.sv
module tiny_rimm_core
  import trc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REG_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [10:0]       pc_o,
  input  logic [13:0]       instr_i,
  output logic [7:0]        dbus_addr_o,
  output logic              dbus_rd_o,
  output logic              dbus_wr_o,
  output logic [DATA_W-1:0] dbus_wdata_o,
  input  logic [DATA_W-1:0] dbus_rdata_i
);
  localparam int SEL_W = $clog2(REG_COUNT);

  opcode_e           op;
  ctrl_t             ctrl;
  logic [SEL_W-1:0]  sel;
  logic [IMM_W-1:0]  imm;
  logic [TGT_W-1:0]  target;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] reg_val;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] wb_data;
  logic              alu_ne;
  logic              take_jump;
  logic [TGT_W-1:0]  pc_q;
  logic              flag_q;

  assign op      = opcode_e'(instr_i[INSTR_W-1 -: OPC_W]);
  assign sel     = instr_i[IMM_W +: SEL_W];
  assign imm     = instr_i[IMM_W-1:0];
  assign target  = instr_i[TGT_W-1:0];
  assign imm_ext = DATA_W'(imm);

  trc_decoder u_dec (
    .op   (op),
    .ctrl (ctrl)
  );

  trc_regfile #(
    .DATA_W    (DATA_W),
    .REG_COUNT (REG_COUNT)
  ) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (ctrl.reg_we),
    .sel   (sel),
    .wdata (wb_data),
    .rdata (reg_val)
  );

  trc_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op     (ctrl.alu_op),
    .a      (reg_val),
    .b      (imm_ext),
    .result (alu_res),
    .differ (alu_ne)
  );

  assign wb_data   = ctrl.sel_mem ? dbus_rdata_i : alu_res;
  assign take_jump = ctrl.jump || (ctrl.jump_ne && flag_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      pc_q <= take_jump ? target : pc_q + 1'b1;
      if (ctrl.flag_we) begin
        flag_q <= alu_ne;
      end
    end
  end

  assign pc_o         = pc_q;
  assign dbus_addr_o  = imm;
  assign dbus_rd_o    = ctrl.mem_rd;
  assign dbus_wr_o    = ctrl.mem_wr;
  assign dbus_wdata_o = reg_val;
endmodule

// File: rtl/trc_core_chk.sv
module trc_core_chk
  import trc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [10:0] pc,
  input logic [13:0] instr,
  input logic        rd,
  input logic        wr,
  input logic [7:0]  addr,
  input logic        flag
);
  logic [2:0] op_now;
  assign op_now = instr[13:11];

  p_reset_pc_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == 11'd0));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(op_now) != OP_JMP) &&
     !(($past(op_now) == OP_JMPNE) && $past(flag)))
    |-> (pc == 11'($past(pc) + 11'd1)));

  p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(op_now) != OP_CMP)) |-> (flag == $past(flag)));

  p_jump_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(op_now) == OP_JMP)) |-> (pc == $past(instr[10:0])));

  p_jmpne_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(op_now) == OP_JMPNE) && $past(flag))
    |-> (pc == $past(instr[10:0])));

  p_store_r8: assert property (@(posedge clk) disable iff (rst)
    (op_now == OP_STORE) |-> (wr && !rd && (addr == instr[7:0])));

  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    (op_now == OP_LOAD) |-> (rd && !wr && (addr == instr[7:0])));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (op_now == OP_IDLE) |-> (!rd && !wr));

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(rd && wr));
endmodule

bind tiny_rimm_core trc_core_chk chk_i (
  .clk   (clk),
  .rst   (rst),
  .pc    (pc_o),
  .instr (instr_i),
  .rd    (dbus_rd_o),
  .wr    (dbus_wr_o),
  .addr  (dbus_addr_o),
  .flag  (flag_q)
);

// File: tb/tiny_rimm_core_tb_top.sv
`timescale 1ns/1ps
module tiny_rimm_core_tb_top;
  localparam int DW    = 8;
  localparam int DEPTH = 2048;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [10:0]   pc;
  logic [13:0]   instr;
  logic [7:0]    addr;
  logic          rd, wr;
  logic [DW-1:0] wdata, rdata;

  logic [13:0]   rom  [DEPTH];
  logic [DW-1:0] dmem [256];
  string         tag_at [32];

  always #2.5 clk = ~clk;

  assign instr = rom[pc];
  assign rdata = dmem[addr];
  always @(posedge clk) if (wr) dmem[addr] <= wdata;

  tiny_rimm_core #(.DATA_W(DW), .REG_COUNT(8)) dut_i (
    .clk(clk), .rst(rst), .pc_o(pc), .instr_i(instr),
    .dbus_addr_o(addr), .dbus_rd_o(rd), .dbus_wr_o(wr),
    .dbus_wdata_o(wdata), .dbus_rdata_i(rdata));

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  // reference model state
  logic [DW-1:0] m_reg [8];
  logic          m_flag;
  logic [10:0]   m_pc;
  string         ptag;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [13:0] enc_ri(logic [2:0] op, logic [2:0] r, logic [7:0] imm);
    return {op, r, imm};
  endfunction

  function automatic logic [13:0] enc_j(logic [2:0] op, logic [10:0] t);
    return {op, t};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_flag = 1'b0;
    m_pc   = '0;
    ptag   = "R1";
  endtask

  // compare outputs for the instruction now present, then advance model
  task automatic step();
    logic [13:0] w;
    logic [2:0]  op, r;
    logic [7:0]  imm;
    string       stag, dtag;
    chk(pc == m_pc, ptag, "pc", pc, m_pc);
    w   = rom[m_pc];
    op  = w[13:11];
    r   = w[10:8];
    imm = w[7:0];
    case (op)
      3'b111:  stag = "R9";
      3'b110:  stag = "R8";
      3'b101:  stag = "R10";
      default: stag = "R11";
    endcase
    dtag = (m_pc < 32 && tag_at[m_pc] != "") ? tag_at[m_pc] : stag;
    chk(rd == (op == 3'b111), stag, "rd strobe", rd, op == 3'b111);
    chk(wr == (op == 3'b110), stag, "wr strobe", wr, op == 3'b110);
    if (op == 3'b111 || op == 3'b110) chk(addr == imm, stag, "bus addr", addr, imm);
    if (op == 3'b110) chk(wdata == m_reg[r], dtag, "store data", wdata, m_reg[r]);
    if (m_pc < 32 && tag_at[m_pc] != "") ptag = tag_at[m_pc];
    else if (op == 3'b011) ptag = "R6";
    else if (op == 3'b100) ptag = "R7";
    else ptag = "R2";
    case (op)
      3'b000: m_reg[r] = m_reg[r] + imm;
      3'b001: m_flag = (m_reg[r] != imm);
      3'b010: m_reg[r] = imm;
      3'b111: m_reg[r] = dmem[imm];
      default: ;
    endcase
    if (op == 3'b011 || (op == 3'b100 && m_flag)) m_pc = w[10:0];
    else m_pc = m_pc + 11'd1;
  endtask

  task automatic fill();
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < 256; i++) dmem[i] = 8'(i * 7 + 3);
    dmem[8'h40] = 8'hC3;
    for (int i = 0; i < 32; i++) tag_at[i] = "";
    // directed prefix
    rom[0] = enc_j(3'b100, 11'd20);            tag_at[0] = "R1";
    for (int k = 0; k < 8; k++) begin
      rom[1 + k] = enc_ri(3'b110, 3'(k), 8'(8'h20 + k));
      tag_at[1 + k] = "R1";
    end
    rom[9]  = enc_ri(3'b010, 3'd1, 8'd200);    tag_at[9]  = "R4";
    rom[10] = enc_ri(3'b000, 3'd1, 8'd100);    tag_at[10] = "R3";
    rom[11] = enc_ri(3'b110, 3'd1, 8'h30);     tag_at[11] = "R3";
    rom[12] = enc_ri(3'b010, 3'd2, 8'h5A);     tag_at[12] = "R4";
    rom[13] = enc_ri(3'b001, 3'd2, 8'h5A);     tag_at[13] = "R5";
    rom[14] = enc_ri(3'b110, 3'd2, 8'h31);     tag_at[14] = "R5";
    rom[15] = enc_j(3'b100, 11'd100);          tag_at[15] = "R7";
    rom[16] = enc_ri(3'b001, 3'd2, 8'h01);     tag_at[16] = "R5";
    rom[17] = enc_j(3'b100, 11'd19);           tag_at[17] = "R7";
    rom[18] = enc_ri(3'b010, 3'd2, 8'h00);
    rom[19] = enc_ri(3'b101, 3'd2, 8'h55);     tag_at[19] = "R10";
    rom[20] = enc_ri(3'b110, 3'd2, 8'h32);     tag_at[20] = "R10";
    rom[21] = enc_ri(3'b110, 3'd3, 8'h05);     tag_at[21] = "R8";
    rom[22] = enc_ri(3'b111, 3'd4, 8'h40);     tag_at[22] = "R9";
    rom[23] = enc_ri(3'b110, 3'd4, 8'h33);     tag_at[23] = "R9";
    rom[24] = enc_j(3'b011, 11'd30);           tag_at[24] = "R6";
    for (int i = 25; i < 30; i++) rom[i] = enc_ri(3'b010, 3'd5, 8'hEE);
    // pseudo-random body, jumps always forward by 1..4 (wrapping)
    for (int i = 30; i < DEPTH; i++) begin
      logic [2:0] op;
      logic [7:0] imm;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op = lf[2:0];
      case (op)
        3'b001, 3'b010: imm = lf[6] ? {6'b0, lf[8:7]} : lf[15:8];
        3'b110, 3'b111: imm = {4'h4, lf[11:8]};
        default:        imm = lf[15:8];
      endcase
      if (op == 3'b011 || op == 3'b100)
        rom[i] = enc_j(op, 11'(i + 1 + int'(lf[9:8])));
      else
        rom[i] = enc_ri(op, lf[5:3], imm);
    end
  endtask

  initial begin
    fill();
    model_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    repeat (3000) begin
      step();
      @(negedge clk);
    end
    // second reset with non-zero state: registers and flag must clear (R1)
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    repeat (2600) begin
      step();
      @(negedge clk);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule